// File: doc/BRIEF.md
# Converter Command and Readback Register Interface

This block sits on a simple 32-bit register bus and fronts a local bank of 16-bit converter registers. Software talks to the bank only through command words written to a write-only command port. Each word holds an opcode (no-op, read or write), a bank address and 16 bits of data. The block carries out every command in the cycle it arrives. Results come back through a read-data FIFO that software drains by reading a read-only pop port.

The result path runs one command behind. Each accepted command first pushes the value captured by the command before it, then captures its own: the bank contents for a read, or zero for a write or no-op. Software therefore sends one extra command, usually a no-op, to flush the last result. Around this path are a configuration register, a sticky write-1-to-clear interrupt status, an interrupt mask, a read-only master status and a master control register. The master control register holds a channel-reset bit that blocks commands. A single level interrupt is raised from the unmasked status bits.

Top module: `adc_cmd_regif`

## Requirements
- R1: After reset, reading byte offset 0x00 gives 0x00001814, 0x04 gives 0x00000200, 0x08 gives 0xFFFFFFFF, 0x0C gives 0x00000500 and 0x18 gives 0x00000010. The irq output is low.
- R2: Valid reads are 0x00, 0x04, 0x08, 0x0C, 0x14 and 0x18. Valid writes are 0x00, 0x04, 0x08, 0x10 and 0x18. Any other access changes no state and raises no status bit, and such a read returns 0. When bus_wr and bus_rd are both high, only the write takes effect and bus_rdata is 0.
- R3: A command word holds the opcode in bits 29:26, the bank address in bits 25:16 and the data in bits 15:0. An accepted command pushes the previously captured value into the data FIFO. The captured value is zero after reset.
- R4: Opcode 2 (write) stores bits 15:0 into the addressed bank register and captures zero. Opcode 1 (read) captures the addressed register. Opcode 0 (no-op) captures zero.
- R5: Opcodes other than 0, 1 and 2 push nothing and capture nothing.
- R6: Commands are dropped while bit 4 of master control is 1. A read or write whose address is 128 or more is dropped. A no-op with such an address is still accepted.
- R7: Reading 0x14 pops the oldest FIFO entry and returns it zero-extended. When the FIFO is empty, the read returns 0 and the level stays at 0.
- R8: The data FIFO holds 15 entries. A push into a full FIFO is discarded, but the command still updates the captured value.
- R9: Reading 0x0C gives the FIFO level in bits 15:12, a constant 1 in bit 10, full in bit 9 when the level is 15, empty in bit 8 when the level is 0, and zeros elsewhere.
- R10: Writing 0x04 clears the status bits written as 1. On every valid write and on every pop-port read, bit 9 is set. On those same events, bit 8 is set if the level after the access exceeds config bits 19:16.
- R11: irq is high exactly when some status bit is 1 and the matching mask bit is 0.
- R12: A write to 0x08 keeps only bits 9:0. A write to 0x18 is ANDed with 0x00FFFEFF. A write to 0x00 is stored in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, valid while bus_rd is high |
| irq | output | 1 | Level interrupt |

## Verification
The bench concentrates on the one-command lag. It checks that a read result comes out only after a later command, and that the first pop after reset is zero. A design that pushed the current value instead of the previous one would return the data one pop too early. Further checks cover a push into a full FIFO, where the level must stay at 15 while the captured value still moves on, and a pop from an empty FIFO, which must return 0 without wrapping the level. Commands dropped for channel reset, an out-of-range address or an unknown opcode must leave the level unchanged. The sticky threshold bit must re-arm on a write-1-to-clear while the level stays above the threshold, and must clear only once the level has fallen.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

   // Byte offsets on the register bus
   localparam int OFF_CFG  = 'h00;
   localparam int OFF_STS  = 'h04;
   localparam int OFF_MASK = 'h08;
   localparam int OFF_MSTS = 'h0C;
   localparam int OFF_CMD  = 'h10;
   localparam int OFF_POP  = 'h14;
   localparam int OFF_MCTL = 'h18;

   localparam int BUS_W  = 32;
   localparam int WORD_W = 16;
   localparam int STS_W  = 10;
   localparam int LVL_FIELD_W = 4;

   localparam int STS_CMD_LOW = 9;
   localparam int STS_DAT_HI  = 8;
   localparam int MCTL_CHRST  = 4;
   localparam int THR_LSB     = 16;

   localparam logic [BUS_W-1:0] CFG_RST   = 32'h0000_1814;
   localparam logic [BUS_W-1:0] MCTL_RST  = 32'h0000_0010;
   localparam logic [BUS_W-1:0] MCTL_KEEP = 32'h00FF_FEFF;
   localparam logic [STS_W-1:0] STS_RST   = 10'h200;

   typedef enum logic [3:0] {
      OP_NOP   = 4'd0,
      OP_READ  = 4'd1,
      OP_WRITE = 4'd2
   } cmd_op_e;

   typedef struct packed {
      logic [1:0]        spare;
      logic [3:0]        op;
      logic [9:0]        addr;
      logic [WORD_W-1:0] data;
   } cmd_word_t;

endpackage

// File: rtl/adc_regif_bank.sv
module adc_regif_bank #(
   parameter int N  = 128,
   parameter int DW = 16,
   localparam int AW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem_q [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/adc_regif_fifo.sv
module adc_regif_fifo #(
   parameter int DEPTH = 15,
   parameter int DW    = 16,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);

   logic [DW-1:0] mem_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [LW-1:0] lvl_q;
   logic          do_push, do_pop;

   assign full    = (lvl_q == LW'(DEPTH));
   assign empty   = (lvl_q == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (do_push) begin
            mem_q[wp_q] <= push_data;
            wp_q        <= bump(wp_q);
         end
         if (do_pop) rp_q <= bump(rp_q);
         if (do_push && !do_pop)      lvl_q <= lvl_q + 1'b1;
         else if (do_pop && !do_push) lvl_q <= lvl_q - 1'b1;
      end
   end

   assign head  = empty ? '0 : mem_q[rp_q];
   assign level = lvl_q;

endmodule

// File: rtl/adc_regif_cmd.sv
module adc_regif_cmd
   import adc_regif_pkg::*;
#(
   parameter int BANK_N = 128,
   localparam int AW = (BANK_N > 1) ? $clog2(BANK_N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic              chan_rst,
   input  logic [BUS_W-1:0]  word,
   input  logic              fifo_full,
   input  logic [WORD_W-1:0] bank_rdata,
   output logic [AW-1:0]     bank_addr,
   output logic              bank_we,
   output logic [WORD_W-1:0] bank_wdata,
   output logic              push,
   output logic [WORD_W-1:0] push_data
);

   cmd_word_t         cw;
   logic              op_known, op_nop, op_rd, op_wr, in_range, go;
   logic [WORD_W-1:0] held_q;

   assign cw       = cmd_word_t'(word[29:0] | 30'd0);
   assign op_nop   = (cw.op == OP_NOP);
   assign op_rd    = (cw.op == OP_READ);
   assign op_wr    = (cw.op == OP_WRITE);
   assign op_known = op_nop | op_rd | op_wr;
   assign in_range = ({22'd0, cw.addr} < BANK_N);
   assign go       = strobe & ~chan_rst & op_known & (op_nop | in_range);

   assign bank_addr  = cw.addr[AW-1:0];
   assign bank_we    = go & op_wr;
   assign bank_wdata = cw.data;

   assign push      = go & ~fifo_full;
   assign push_data = held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  held_q <= '0;
      else if (go) held_q <= op_rd ? bank_rdata : '0;
   end

endmodule

// File: rtl/adc_cmd_regif.sv
module adc_cmd_regif
   import adc_regif_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int FIFO_DEPTH = 15,
   parameter int BANK_N     = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              irq
);

   localparam int BAW = (BANK_N > 1) ? $clog2(BANK_N) : 1;
   localparam int LW  = $clog2(FIFO_DEPTH + 1);

   generate
      if (FIFO_DEPTH < 1 || FIFO_DEPTH > (2**LVL_FIELD_W) - 1) begin : g_bad_depth
         $error("FIFO_DEPTH must fit the 4-bit level field");
      end
      if (BANK_N < 2 || BANK_N > 1024) begin : g_bad_bank
         $error("BANK_N must be reachable by the 10-bit command address");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   // address decode
   logic hit_cfg, hit_sts, hit_mask, hit_msts, hit_cmd, hit_pop, hit_mctl;
   assign hit_cfg  = (bus_addr == ADDR_W'(OFF_CFG));
   assign hit_sts  = (bus_addr == ADDR_W'(OFF_STS));
   assign hit_mask = (bus_addr == ADDR_W'(OFF_MASK));
   assign hit_msts = (bus_addr == ADDR_W'(OFF_MSTS));
   assign hit_cmd  = (bus_addr == ADDR_W'(OFF_CMD));
   assign hit_pop  = (bus_addr == ADDR_W'(OFF_POP));
   assign hit_mctl = (bus_addr == ADDR_W'(OFF_MCTL));

   logic wr_ok, rd_act, pop, upd;
   assign wr_ok  = bus_wr & (hit_cfg | hit_sts | hit_mask | hit_cmd | hit_mctl);
   assign rd_act = bus_rd & ~bus_wr;
   assign pop    = rd_act & hit_pop;
   assign upd    = wr_ok | pop;

   // control registers
   logic [31:0]      cfg_q, mask_q, mctl_q, cfg_nx;
   logic [STS_W-1:0] sts_q, sts_nx;

   // command path, bank and FIFO
   logic [BAW-1:0]    bank_addr;
   logic              bank_we, push, f_full, f_empty;
   logic [WORD_W-1:0] bank_wdata, bank_rdata, push_data, f_head;
   logic [LW-1:0]     f_level, lvl_nx;

   adc_regif_cmd #(.BANK_N(BANK_N)) cmd_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (bus_wr & hit_cmd),
      .chan_rst   (mctl_q[MCTL_CHRST]),
      .word       (bus_wdata),
      .fifo_full  (f_full),
      .bank_rdata (bank_rdata),
      .bank_addr  (bank_addr),
      .bank_we    (bank_we),
      .bank_wdata (bank_wdata),
      .push       (push),
      .push_data  (push_data)
   );

   adc_regif_bank #(.N(BANK_N), .DW(WORD_W)) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we),
      .waddr (bank_addr),
      .wdata (bank_wdata),
      .raddr (bank_addr),
      .rdata (bank_rdata)
   );

   adc_regif_fifo #(.DEPTH(FIFO_DEPTH), .DW(WORD_W)) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .pop       (pop),
      .head      (f_head),
      .level     (f_level),
      .full      (f_full),
      .empty     (f_empty)
   );

   // level after this cycle's access (push and pop never coincide)
   always_comb begin
      lvl_nx = f_level;
      if (push && !f_full)      lvl_nx = f_level + 1'b1;
      else if (pop && !f_empty) lvl_nx = f_level - 1'b1;
   end

   assign cfg_nx = (bus_wr & hit_cfg) ? bus_wdata : cfg_q;

   always_comb begin
      sts_nx = sts_q;
      if (bus_wr && hit_sts) sts_nx = sts_q & ~bus_wdata[STS_W-1:0];
      if (upd) begin
         sts_nx[STS_CMD_LOW] = 1'b1;
         if ({{(8-LW){1'b0}}, lvl_nx} > {4'd0, cfg_nx[THR_LSB +: LVL_FIELD_W]})
            sts_nx[STS_DAT_HI] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= CFG_RST;
         sts_q  <= STS_RST;
         mask_q <= '1;
         mctl_q <= MCTL_RST;
      end else begin
         cfg_q <= cfg_nx;
         sts_q <= sts_nx;
         if (bus_wr && hit_mask) mask_q <= {{(32-STS_W){1'b0}}, bus_wdata[STS_W-1:0]};
         if (bus_wr && hit_mctl) mctl_q <= bus_wdata & MCTL_KEEP;
      end
   end

   assign irq = |(sts_q & ~mask_q[STS_W-1:0]);

   // read mux
   logic [31:0] msts;
   always_comb begin
      msts = '0;
      msts[12 +: LVL_FIELD_W] = LVL_FIELD_W'(f_level);
      msts[10] = 1'b1;
      msts[9]  = f_full;
      msts[8]  = f_empty;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_act) begin
         unique case (1'b1)
            hit_cfg:  bus_rdata = cfg_q;
            hit_sts:  bus_rdata = {{(32-STS_W){1'b0}}, sts_q};
            hit_mask: bus_rdata = mask_q;
            hit_msts: bus_rdata = msts;
            hit_pop:  bus_rdata = {{(32-WORD_W){1'b0}}, f_head};
            hit_mctl: bus_rdata = mctl_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/adc_regif_checker.sv
module adc_regif_checker #(
   parameter int ADDR_W     = 8,
   parameter int FIFO_DEPTH = 15,
   parameter int LW         = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [31:0]       bus_wdata,
   input logic [LW-1:0]     level,
   input logic [31:0]       mctl,
   input logic [31:0]       mask,
   input logic [9:0]        sts,
   input logic              irq
);

   // R8: the level never passes the depth
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(FIFO_DEPTH));

   // R6: a command under channel reset leaves the level alone
   assert_chan_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'('h10) && mctl[4]) |=> $stable(level));

   // R7: popping an empty FIFO keeps it empty
   assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == ADDR_W'('h14) && level == '0) |=> (level == '0));

   // R10: a valid write re-arms status bit 9
   assert_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'('h04)) |=> sts[9]);

   // R12: mask writes drop the upper bits
   assert_mask_trim_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'('h08)) |=> (mask[31:10] == '0));

   // R11: with every bit masked the interrupt stays low
   assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[9:0] == 10'h3FF) |-> !irq);

   // R8: level moves by at most one per cycle
   assert_level_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (level == $past(level)) || (level == $past(level) + 1'b1) || (level == $past(level) - 1'b1));

endmodule

bind adc_cmd_regif adc_regif_checker #(
   .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .LW(LW)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .level     (f_level),
   .mctl      (mctl_q),
   .mask      (mask_q),
   .sts       (sts_q),
   .irq       (irq)
);

// File: tb/adc_cmd_regif_tb_top.sv
module adc_cmd_regif_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int bad = 0;
   int cycles = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   adc_cmd_regif dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference
   int unsigned m_cfg, m_sts, m_mask, m_mctl, m_prev;
   int unsigned m_bank [128];
   int unsigned m_q [$];

   function automatic int unsigned m_read(input int unsigned a);
      case (a)
         'h00: return m_cfg;
         'h04: return m_sts;
         'h08: return m_mask;
         'h0C: return (m_q.size() << 12) | 32'h400 |
                      ((m_q.size() == 15) ? 32'h200 : 0) |
                      ((m_q.size() == 0) ? 32'h100 : 0);
         'h14: return (m_q.size() > 0) ? m_q[0] : 0;
         'h18: return m_mctl;
         default: return 0;
      endcase
   endfunction

   function automatic void m_refresh();
      m_sts |= 32'h200;
      if (m_q.size() > ((m_cfg >> 16) & 15)) m_sts |= 32'h100;
   endfunction

   function automatic void m_command(input int unsigned d);
      int unsigned op = (d >> 26) & 15;
      int unsigned ra = (d >> 16) & 1023;
      if ((m_mctl & 16) != 0) return;
      if (!(op == 0 || ((op == 1 || op == 2) && ra < 128))) return;
      if (op == 2) m_bank[ra] = d & 16'hFFFF;
      if (m_q.size() < 15) m_q.push_back(m_prev);
      m_prev = (op == 1) ? m_bank[ra] : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cfg = 32'h1814; m_sts = 32'h200; m_mask = 32'hFFFFFFFF;
         m_mctl = 32'h10; m_prev = 0;
         foreach (m_bank[i]) m_bank[i] = 0;
         m_q.delete();
      end else if (bus_wr) begin
         case (bus_addr)
            8'h00: begin m_cfg = bus_wdata; m_refresh(); end
            8'h04: begin m_sts &= ~bus_wdata; m_refresh(); end
            8'h08: begin m_mask = bus_wdata & 32'h3FF; m_refresh(); end
            8'h10: begin m_command(bus_wdata); m_refresh(); end
            8'h18: begin m_mctl = bus_wdata & 32'h00FFFEFF; m_refresh(); end
            default: ;
         endcase
      end else if (bus_rd && bus_addr == 8'h14) begin
         if (m_q.size() > 0) void'(m_q.pop_front());
         m_refresh();
      end
   end

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FIFO-bench FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
      end
   endtask

   // interrupt compared on every cycle (R11)
   always @(negedge clk) begin
      #2;
      if (rst_n) check({31'd0, irq}, ((m_sts & ~m_mask) != 0) ? 32'd1 : 32'd0, cur_req, "irq R11");
   end

   task automatic acc(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d, input string req);
      @(negedge clk);
      cur_req = req;
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
      #1;
      if (r) check(bus_rdata, w ? 32'd0 : m_read(a), req, $sformatf("rdata @%02h", a));
      @(posedge clk);
      #1;
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
      acc(1'b1, 1'b0, a, d, req);
   endtask

   task automatic rd(input logic [7:0] a, input string req);
      acc(1'b0, 1'b1, a, 32'd0, req);
   endtask

   function automatic logic [31:0] cw(input int op, input int ra, input int d);
      return (32'(op & 15) << 26) | (32'(ra & 1023) << 16) | 32'(d & 16'hFFFF);
   endfunction

   initial begin : watchdog
      wait (cycles > 150000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   always @(posedge clk) cycles++;

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1"); rd(8'h0C, "R1"); rd(8'h18, "R1");

      // R2 decode: wrong direction and unknown offsets
      rd(8'h10, "R2"); rd(8'h1C, "R2"); rd(8'h40, "R2"); rd(8'h02, "R2");
      wr(8'h0C, 32'hFFFF_FFFF, "R2"); wr(8'h14, 32'h1234, "R2"); wr(8'h20, 32'hFFFF, "R2");
      rd(8'h04, "R2"); rd(8'h0C, "R2"); rd(8'h00, "R2");
      acc(1'b1, 1'b1, 8'h00, 32'h0000_1814, "R2");

      // R12 write masking
      wr(8'h18, 32'hFFFF_FFFF, "R12"); rd(8'h18, "R12");
      wr(8'h18, 32'h0, "R12"); rd(8'h18, "R12");
      wr(8'h08, 32'hFFFF_FFFF, "R12"); rd(8'h08, "R12");
      wr(8'h00, 32'h1234_5678, "R12"); rd(8'h00, "R12");
      wr(8'h00, 32'h0000_1814, "R12");

      // R3 R4 lagged results
      wr(8'h10, cw(2, 5, 'hABCD), "R4");
      wr(8'h10, cw(1, 5, 0), "R3");
      wr(8'h10, cw(0, 0, 0), "R3");
      rd(8'h0C, "R9");
      for (int i = 0; i < 4; i++) rd(8'h14, "R7");
      rd(8'h0C, "R7");

      // R5 unknown opcodes
      wr(8'h10, cw(3, 5, 0), "R5"); wr(8'h10, cw(15, 5, 0), "R5");
      rd(8'h0C, "R5");

      // R6 dropped commands
      wr(8'h10, cw(1, 200, 0), "R6"); wr(8'h10, cw(2, 128, 7), "R6");
      rd(8'h0C, "R6");
      wr(8'h10, cw(0, 900, 0), "R6"); rd(8'h0C, "R6"); rd(8'h14, "R6");
      wr(8'h18, 32'h10, "R6"); wr(8'h10, cw(1, 5, 0), "R6"); rd(8'h0C, "R6");
      wr(8'h18, 32'h0, "R6");

      // R8 fill past full
      for (int i = 0; i < 8; i++) wr(8'h10, cw(2, 10 + i, 'h100 * i + 3), "R8");
      for (int i = 0; i < 12; i++) wr(8'h10, cw(1, 10 + (i % 8), 0), "R8");
      rd(8'h0C, "R9");
      for (int i = 0; i < 16; i++) rd(8'h14, "R8");
      wr(8'h10, cw(0, 0, 0), "R8"); rd(8'h14, "R8");

      // R10 R11 threshold and interrupt
      wr(8'h00, 32'h0002_1814, "R10");
      for (int i = 0; i < 3; i++) wr(8'h10, cw(0, 0, 0), "R10");
      rd(8'h04, "R10");
      wr(8'h08, 32'h2FF, "R11"); rd(8'h04, "R11");
      wr(8'h04, 32'h100, "R10"); rd(8'h04, "R10");
      rd(8'h14, "R10"); rd(8'h14, "R10");
      wr(8'h04, 32'h100, "R10"); rd(8'h04, "R10");
      wr(8'h04, 32'h200, "R10"); rd(8'h04, "R10");
      wr(8'h08, 32'h1FF, "R11"); rd(8'h04, "R11");
      wr(8'h08, 32'h3FF, "R11");
      repeat (3) @(posedge clk);

      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule